// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This unit keeps the exception state of a floating-point coprocessor. It has three fields. The first is an eight-class exception byte that describes the most recent operation. The second is an enable byte that uses the same bit positions as the exception byte. The third is a five-bit sticky accrued byte.

When the arithmetic datapath finishes an operation, it pulses `op_done` and presents the raised flags on `exc_in`. The exception byte is then replaced by those flags. If the operation is one that accumulates, the flags are also folded into the accrued bits. A trap request pulses when any raised class is also enabled.

Software can read and write the status word (exception and accrued bytes) and the control byte (enables). A null-state restore clears all state, as reset does. Traps come only from operations, never from software writes.

All inputs are plain control and status pins sampled on the rising clock edge. The unit accepts one completion every cycle and never stalls, so it has no valid/ready handshake and no back-pressure.

Top module: `fpx_status_unit`

## Requirements
- R1: After synchronous reset `rst`, `sts_rdata`, `ctl_rdata` and `trap_req` are all zero.
- R2: On an edge with `op_done` high and no status write, `sts_rdata[15:8]` becomes `exc_in`. The exception bit positions are: 7 unordered compare, 6 signalling NaN, 5 operand error, 4 overflow, 3 underflow, 2 divide by zero, 1 inexact-2, 0 inexact-1.
- R3: With `op_done` and `op_affects_aexc` high, the accrued bits in `sts_rdata` are ORed with a folded value computed from `exc_in`, as follows:
  - bit 7 (invalid) takes e7|e6|e5;
  - bit 6 (overflow) takes e4;
  - bit 5 (underflow) takes e3&e1;
  - bit 4 (divide by zero) takes e2;
  - bit 3 (inexact) takes e1|e0|e4.
- R4: Accrued bits are sticky. An operation never clears them.
- R5: An `op_done` with `op_affects_aexc` low leaves the accrued bits unchanged.
- R6: `trap_req` is high in the cycle after an `op_done` edge exactly when `exc_in & enable` is nonzero. Here `enable` is the value held before that edge.
- R7: A status write (`sts_we`) loads `sts_wdata[15:3]`, and bits 2:0 always read zero. A status write never causes `trap_req`, whatever the enables hold.
- R8: A control write (`ctl_we`) loads the enable byte, which reads back on `ctl_rdata`.
- R9: `restore_null` clears the exception, accrued and enable bytes and suppresses any trap from the same edge.
- R10: When a status write and `op_done` share an edge, the write data wins for both status fields. The trap request is still computed from the operation.
- R11: Accrued bits have no influence on `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_done | input | 1 | Operation completed this cycle |
| op_affects_aexc | input | 1 | Completed operation accumulates into the accrued byte |
| exc_in | input | 8 | Exception flags raised by the operation |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 16 | Status write data: exception byte [15:8], accrued bits [7:3] |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | New enable byte |
| restore_null | input | 1 | Null-state restore, clears all state |
| sts_rdata | output | 16 | Status read value |
| ctl_rdata | output | 8 | Enable byte read value |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Two functions can collide in one cycle: a software status write and the completion of an operation. The bench drives `sts_we` and `op_done` on the same edge, with enabled classes in `exc_in`. It then expects the status word to equal the written data and `trap_req` to still pulse from the operation's flags. A second collision pairs a control write with `op_done`; there the trap must be judged against the old enable byte. Random stimulus also produces both collisions, and each step is compared with a bench model that applies the same precedence.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W = 8;
  localparam int AEX_W = 5;

  // exception byte bit positions
  localparam int E_BSUN  = 7;
  localparam int E_SNAN  = 6;
  localparam int E_OPERR = 5;
  localparam int E_OVFL  = 4;
  localparam int E_UNFL  = 3;
  localparam int E_DZ    = 2;
  localparam int E_INEX2 = 1;
  localparam int E_INEX1 = 0;

  // accrued vector positions (occupy status bits 7..3)
  localparam int A_IOP  = 4;
  localparam int A_OVFL = 3;
  localparam int A_UNFL = 2;
  localparam int A_DZ   = 1;
  localparam int A_INEX = 0;

  typedef logic [EXC_W-1:0] exc_t;
  typedef logic [AEX_W-1:0] aex_t;
endpackage

// File: rtl/fpx_accrue.sv
module fpx_accrue
  import fpx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ld,
  input  aex_t ld_val,
  input  logic acc_en,
  input  exc_t exc,
  output aex_t aex_q
);
  aex_t folded;

  always_comb begin
    folded         = '0;
    folded[A_IOP]  = exc[E_BSUN] | exc[E_SNAN] | exc[E_OPERR];
    folded[A_OVFL] = exc[E_OVFL];
    folded[A_UNFL] = exc[E_UNFL] & exc[E_INEX2];
    folded[A_DZ]   = exc[E_DZ];
    folded[A_INEX] = exc[E_INEX1] | exc[E_INEX2] | exc[E_OVFL];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  aex_q <= '0;
    else if (ld)     aex_q <= ld_val;
    else if (acc_en) aex_q <= aex_q | folded;
  end

  // R4: without clear or load, no accrued bit ever falls
  assert_aex_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld) |=> ((aex_q & $past(aex_q)) == $past(aex_q)));

  // R5: without accumulation, clear or load, accrued bits hold
  assert_aex_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld && !acc_en) |=> $stable(aex_q));
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         kill,
  input  logic         fire,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         trap_q
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cls
    assign hit[i] = flags[i] & enables[i];
  end

  always_ff @(posedge clk) begin
    if (rst || kill) trap_q <= 1'b0;
    else             trap_q <= fire & (|hit);
  end

  // R6: a trap request only ever follows an operation completion
  assert_trap_from_op_R6: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> $past(fire));

  // R9: restore kills the trap of the same edge
  assert_trap_killed_R9: assert property (@(posedge clk) disable iff (rst)
    kill |=> !trap_q);
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int STS_W = 2 * EXC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_done,
  input  logic             op_affects_aexc,
  input  logic [EXC_W-1:0] exc_in,
  input  logic             sts_we,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic             ctl_we,
  input  logic [EXC_W-1:0] ctl_wdata,
  input  logic             restore_null,
  output logic [STS_W-1:0] sts_rdata,
  output logic [EXC_W-1:0] ctl_rdata,
  output logic             trap_req
);
  localparam int PAD = EXC_W - AEX_W;
  localparam logic [STS_W-1:0] STS_MASK = {{(STS_W-PAD){1'b1}}, {PAD{1'b0}}};

  exc_t exc_q;
  exc_t en_q;
  aex_t aex_q;

  always_ff @(posedge clk) begin
    if (rst || restore_null) begin
      exc_q <= '0;
      en_q  <= '0;
    end else begin
      if (sts_we)       exc_q <= sts_wdata[STS_W-1 -: EXC_W];
      else if (op_done) exc_q <= exc_in;
      if (ctl_we)       en_q  <= ctl_wdata;
    end
  end

  fpx_accrue u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr    (restore_null),
    .ld     (sts_we),
    .ld_val (sts_wdata[EXC_W-1 -: AEX_W]),
    .acc_en (op_done & op_affects_aexc),
    .exc    (exc_in),
    .aex_q  (aex_q)
  );

  fpx_trap_gen #(.N(EXC_W)) u_trap (
    .clk     (clk),
    .rst     (rst),
    .kill    (restore_null),
    .fire    (op_done),
    .flags   (exc_in),
    .enables (en_q),
    .trap_q  (trap_req)
  );

  assign sts_rdata = {exc_q, aex_q, {PAD{1'b0}}};
  assign ctl_rdata = en_q;

  // R2: an operation without a competing write replaces the exception byte
  assert_exc_load_R2: assert property (@(posedge clk) disable iff (rst)
    (op_done && !sts_we && !restore_null) |=> (exc_q == $past(exc_in)));

  // R7: a software status write alone never requests a trap
  assert_write_no_trap_R7: assert property (@(posedge clk) disable iff (rst)
    (sts_we && !op_done) |=> !trap_req);

  // R10: the write wins over a simultaneous operation
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (sts_we && !restore_null) |=> (sts_rdata == ($past(sts_wdata) & STS_MASK)));

  // R8: control write lands in the enable byte
  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !restore_null) |=> (ctl_rdata == $past(ctl_wdata)));

  // R9: restore leaves all state cleared
  assert_restore_clear_R9: assert property (@(posedge clk) disable iff (rst)
    restore_null |=> (sts_rdata == '0 && ctl_rdata == '0));
endmodule

// File: tb/fpx_status_unit_test.sv
module fpx_status_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_done, op_affects_aexc, sts_we, ctl_we, restore_null;
  logic [7:0]  exc_in, ctl_wdata;
  logic [15:0] sts_wdata;
  logic [15:0] sts_rdata;
  logic [7:0]  ctl_rdata;
  logic        trap_req;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_exc, m_en;
  logic [4:0] m_aex;
  logic       m_trap;

  always #4 clk = ~clk;

  fpx_status_unit uut (
    .clk(clk), .rst(rst), .op_done(op_done), .op_affects_aexc(op_affects_aexc),
    .exc_in(exc_in), .sts_we(sts_we), .sts_wdata(sts_wdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .restore_null(restore_null), .sts_rdata(sts_rdata),
    .ctl_rdata(ctl_rdata), .trap_req(trap_req)
  );

  function automatic logic [4:0] fold(input logic [7:0] e);
    logic [4:0] r;
    r[4] = e[7] | e[6] | e[5];
    r[3] = e[4];
    r[2] = e[3] & e[1];
    r[1] = e[2];
    r[0] = e[0] | e[1] | e[4];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic opd, input logic aff, input logic [7:0] e,
                      input logic swe, input logic [15:0] sw,
                      input logic cwe, input logic [7:0] cw, input logic rn,
                      input string tag);
    @(negedge clk);
    op_done = opd; op_affects_aexc = aff; exc_in = e;
    sts_we = swe; sts_wdata = sw; ctl_we = cwe; ctl_wdata = cw; restore_null = rn;
    m_trap = opd && !rn && ((e & m_en) != 8'h00);
    if (rn) begin
      m_exc = '0; m_en = '0; m_aex = '0;
    end else begin
      if (cwe) m_en = cw;
      if (swe) begin
        m_exc = sw[15:8]; m_aex = sw[7:3];
      end else if (opd) begin
        m_exc = e;
        if (aff) m_aex = m_aex | fold(e);
      end
    end
    @(posedge clk); #1;
    chk({tag, " status"}, 32'(sts_rdata), 32'({m_exc, m_aex, 3'b000}));
    chk({tag, " control"}, 32'(ctl_rdata), 32'(m_en));
    chk({tag, " trap"}, 32'(trap_req), 32'(m_trap));
    op_done = 0; sts_we = 0; ctl_we = 0; restore_null = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; op_done = 0; op_affects_aexc = 0; exc_in = 0; sts_we = 0;
    sts_wdata = 0; ctl_we = 0; ctl_wdata = 0; restore_null = 0;
    m_exc = 0; m_en = 0; m_aex = 0; m_trap = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", 32'(sts_rdata), 0);
    chk("R1 reset control", 32'(ctl_rdata), 0);
    chk("R1 reset trap", 32'(trap_req), 0);
    @(negedge clk); rst = 0;

    // R3 fold, one class at a time
    for (int b = 0; b < 8; b++) begin
      step(1, 1, 8'h01 << b, 0, 0, 0, 0, 0, "R3 single class");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R9 restore");
    end
    // R3 underflow needs inexact-2
    step(1, 1, 8'h08, 0, 0, 0, 0, 0, "R3 unfl alone");
    step(1, 1, 8'h0A, 0, 0, 0, 0, 0, "R3 unfl with inex2");
    // R4 sticky across a clean op, R5 non-accumulating op
    step(1, 1, 8'h00, 0, 0, 0, 0, 0, "R4 sticky");
    step(1, 0, 8'hFF, 0, 0, 0, 0, 0, "R5 no accumulate");
    // R8 enables, R6 trap
    step(0, 0, 0, 0, 0, 1, 8'h10, 0, "R8 control write");
    step(1, 1, 8'h10, 0, 0, 0, 0, 0, "R6 enabled trap");
    step(1, 1, 8'h01, 0, 0, 0, 0, 0, "R6 disabled class");
    // R7 write never traps, low bits read zero
    step(0, 0, 0, 0, 0, 1, 8'hFF, 0, "R8 all enabled");
    step(0, 0, 0, 1, 16'hFFFF, 0, 0, 0, "R7 write no trap");
    // R11 accrued all ones, no flags -> no trap
    step(1, 1, 8'h00, 0, 0, 0, 0, 0, "R11 accrued no trap");
    // R10 collision
    step(1, 1, 8'h20, 1, 16'h1234, 0, 0, 0, "R10 write vs op");
    // R6 control write with op uses old enables
    step(1, 0, 8'h04, 0, 0, 1, 8'h00, 0, "R6 old enable");
    step(1, 0, 8'h04, 0, 0, 0, 0, 0, "R6 new enable");
    // R9 restore with op
    step(0, 0, 0, 0, 0, 1, 8'hFF, 0, "R8 reenable");
    step(1, 1, 8'hFF, 0, 0, 0, 0, 1, "R9 restore with op");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2] | r[3], 8'($urandom) & 8'($urandom),
           (r[7:4] == 0), 16'($urandom), (r[11:8] < 2), 8'($urandom),
           (r[17:12] == 0), "R2 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule